// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block turns the controller's input clock into the serial clock of an SPI port. It also produces one-cycle rising-edge and falling-edge strobes, so the shift logic knows when to launch and when to capture data. A single 32-bit configuration word controls it. Three 6-bit fields set the period length, the length of the low phase and the length of the high phase, so software sets the duty cycle. One further bit switches to a fixed divide-by-two bypass mode.

The transfer engine holds `run` high while bits are moving. While `run` is low the serial clock rests low and the phase counter is parked. Every new burst therefore begins with a complete low phase before the first rising edge. The usual programming for a divide setting n is: period field = n, low-count field = n, high-count field = ceil((n+1)/2)-1. This gives a period of n+1 input cycles and close to half duty for odd and even periods alike.

Top module: `spi_sclk_divider`

## Requirements
- R1: While `run` is high, the serial clock repeats with a period of P = D+1 input cycles, where D is the period field in bits 17:12. Any D from 1 to 63 is accepted, which covers ratios 2 to 64.
- R2: Within each period, the clock is low for the first K = L-H cycles and high for the rest. L is the low-count field in bits 5:0 and H is the high-count field in bits 11:6. With L=D and H=ceil((D+1)/2)-1, the high phase is ceil((D+1)/2) cycles.
- R3: Bits 30:18 of the configuration word have no effect on the output.
- R4: A period field of 0 behaves exactly like a period field of 1.
- R5: If L is not greater than H, K is 1. If L-H exceeds the effective D, K is clamped to D, which leaves a one-cycle high phase.
- R6: When bit 31 is 1, the clock divides by 2 (one cycle low, then one cycle high) and the three fields are ignored.
- R7: While `run` is low, `sclk`, `rise_stb` and `fall_stb` are 0. In the first output cycle after `run` is sampled high, the period starts at its first low cycle.
- R8: `rise_stb` is 1 exactly in the first cycle of each high phase. `fall_stb` is 1 exactly in the first low cycle that follows a high phase while `run` stays high. Each strobe lasts one cycle.
- R9: Dropping `run` forces `sclk` low on the next cycle and raises no `fall_stb`.
- R10: During and right after synchronous reset, `sclk`, `rise_stb` and `fall_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Clock configuration: bit 31 bypass, 17:12 period, 11:6 high count, 5:0 low count |
| run | input | 1 | Clock enable from the transfer engine |
| sclk | output | 1 | Serial clock, idles low |
| rise_stb | output | 1 | One-cycle strobe in the first high cycle |
| fall_stb | output | 1 | One-cycle strobe in the first low cycle after a high phase |

## Verification
The bench builds the block with its default field width of 6 bits, so the whole ratio range from 2 up to 64 can be reached, including the slowest setting. Bursts cover the following cases: the fastest and slowest ratios, an odd period, an asymmetric duty, a zero period field, both clamp cases of the low phase, bypass with nonzero fields, and ignored upper bits. One burst is cut off during a high phase to show the abort behaviour. Each burst is followed by idle cycles, which check the parked state and confirm that the next burst restarts cleanly.

// File: rtl/spiclk_pkg.sv
`timescale 1ns/1ps
package spiclk_pkg;
    localparam int FLD_W   = 6;
    localparam int CFG_W   = 32;
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = LO_LSB + FLD_W;
    localparam int DIV_LSB = HI_LSB + FLD_W;
    localparam int SRC_BIT = CFG_W - 1;

    typedef struct packed {
        logic             bypass;
        logic [FLD_W-1:0] period;
        logic [FLD_W-1:0] high_cnt;
        logic [FLD_W-1:0] low_cnt;
    } clk_cfg_t;

    function automatic clk_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        clk_cfg_t c;
        c.bypass   = w[SRC_BIT];
        c.period   = w[DIV_LSB +: FLD_W];
        c.high_cnt = w[HI_LSB +: FLD_W];
        c.low_cnt  = w[LO_LSB +: FLD_W];
        return c;
    endfunction
endpackage

// File: rtl/spiclk_cfg_decode.sv
`timescale 1ns/1ps
module spiclk_cfg_decode
    import spiclk_pkg::*;
#(
    parameter int W = FLD_W
) (
    input  logic [CFG_W-1:0] cfg_word,
    output logic [W-1:0]     last_pos,
    output logic [W-1:0]     rise_pos
);
    localparam logic [W-1:0] ONE = W'(1);

    clk_cfg_t      cfg;
    logic [W-1:0]  eff_div;
    logic [W-1:0]  raw_rise;

    always_comb begin
        cfg      = unpack_cfg(cfg_word);
        eff_div  = (cfg.period == '0) ? ONE : W'(cfg.period);
        raw_rise = (cfg.low_cnt > cfg.high_cnt) ?
                   W'(cfg.low_cnt - cfg.high_cnt) : ONE;
        if (cfg.bypass) begin
            last_pos = ONE;
            rise_pos = ONE;
        end else begin
            last_pos = eff_div;
            rise_pos = (raw_rise > eff_div) ? eff_div : raw_rise;
        end
    end
endmodule

// File: rtl/spiclk_phase_ctr.sv
`timescale 1ns/1ps
module spiclk_phase_ctr #(
    parameter int W = spiclk_pkg::FLD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] last_pos,
    output logic [W-1:0] pos_nxt
);
    logic [W-1:0] pos_q;

    always_comb begin
        if (!run)
            pos_nxt = '1;
        else if (pos_q >= last_pos)
            pos_nxt = '0;
        else
            pos_nxt = pos_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '1;
        else
            pos_q <= pos_nxt;
    end

    // R1
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        $past(run) |-> pos_q <= $past(last_pos));

    // R1
    pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && $past(pos_q) >= $past(last_pos)) |-> pos_q == '0);
endmodule

// File: rtl/spiclk_edge_gen.sv
`timescale 1ns/1ps
module spiclk_edge_gen #(
    parameter int W = spiclk_pkg::FLD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] pos_nxt,
    input  logic [W-1:0] rise_pos,
    output logic         sclk,
    output logic         rise_stb,
    output logic         fall_stb
);
    logic high_nxt;

    assign high_nxt = run && (pos_nxt >= rise_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            sclk     <= high_nxt;
            rise_stb <= high_nxt && !sclk;
            fall_stb <= run && !high_nxt && sclk;
        end
    end

    // R8
    rise_align_chk: assert property (@(posedge clk) disable iff (rst)
        rise_stb |-> (sclk && !$past(sclk)));

    // R8
    fall_align_chk: assert property (@(posedge clk) disable iff (rst)
        fall_stb |-> (!sclk && $past(sclk)));

    // R8
    rise_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && !$past(sclk)) |-> rise_stb);

    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sclk) && !sclk && !fall_stb) |-> !$past(run));

    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> (!sclk && !rise_stb && !fall_stb));
endmodule

// File: rtl/spi_sclk_divider.sv
`timescale 1ns/1ps
module spi_sclk_divider
    import spiclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             run,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int W = FLD_W;

    logic [W-1:0] last_pos;
    logic [W-1:0] rise_pos;
    logic [W-1:0] pos_nxt;

    spiclk_cfg_decode #(.W(W)) u_dec (
        .cfg_word (cfg_word),
        .last_pos (last_pos),
        .rise_pos (rise_pos)
    );

    spiclk_phase_ctr #(.W(W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .last_pos (last_pos),
        .pos_nxt  (pos_nxt)
    );

    spiclk_edge_gen #(.W(W)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .pos_nxt  (pos_nxt),
        .rise_pos (rise_pos),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rise_stb && fall_stb));
endmodule

// File: tb/spi_sclk_divider_test.sv
`timescale 1ns/1ps
module spi_sclk_divider_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        run = 1'b0;
    logic        sclk, rise_stb, fall_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic  s;
        logic  r;
        logic  f;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    spi_sclk_divider uut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .run(run),
        .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    function automatic logic [31:0] mk(input bit byp, input int d,
                                       input int h, input int l);
        logic [31:0] w;
        w = '0;
        w[31]    = byp;
        w[17:12] = d[5:0];
        w[11:6]  = h[5:0];
        w[5:0]   = l[5:0];
        return w;
    endfunction

    task automatic burst(input logic [31:0] w, input int len, input string tag);
        int d, h, l, per, k;
        d = int'(w[17:12]);
        h = int'(w[11:6]);
        l = int'(w[5:0]);
        if (w[31]) begin
            per = 2;
            k = 1;
        end else begin
            if (d == 0) d = 1;
            per = d + 1;
            k = (l > h) ? l - h : 1;
            if (k > d) k = d;
        end
        @(negedge clk);
        cfg_word = w;
        run = 1'b1;
        for (int j = 0; j < len; j++) begin
            exp_t e;
            logic cur, prv;
            cur = ((j % per) >= k);
            prv = (j == 0) ? 1'b0 : (((j - 1) % per) >= k);
            e.s = cur;
            e.r = cur && !prv;
            e.f = !cur && prv;
            e.tag = tag;
            q.push_back(e);
        end
        repeat (len) @(negedge clk);
        run = 1'b0;
        for (int j = 0; j < 3; j++) begin
            exp_t e;
            e.s = 1'b0; e.r = 1'b0; e.f = 1'b0;
            e.tag = "R7 R9 idle";
            q.push_back(e);
        end
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (sclk !== e.s || rise_stb !== e.r || fall_stb !== e.f) begin
                errors++;
                $display("FAIL %s: got sclk=%b rise=%b fall=%b expected %b %b %b",
                         e.tag, sclk, rise_stb, fall_stb, e.s, e.r, e.f);
            end
        end
    end

    initial begin
        #(20 * 60000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        checks++;
        if (sclk !== 1'b0 || rise_stb !== 1'b0 || fall_stb !== 1'b0) begin
            errors++;
            $display("FAIL R10: got %b %b %b expected 0 0 0", sclk, rise_stb, fall_stb);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (sclk !== 1'b0 || rise_stb !== 1'b0 || fall_stb !== 1'b0) begin
            errors++;
            $display("FAIL R10: got %b %b %b expected 0 0 0 after release", sclk, rise_stb, fall_stb);
        end
        // R1 R2: fastest ratio 2
        burst(mk(0, 1, 0, 1), 8, "R1 R2 n=1");
        // R1 R2: odd period 3
        burst(mk(0, 2, 1, 2), 12, "R1 R2 n=2");
        // R1 R2 R8: even period 8
        burst(mk(0, 7, 3, 7), 24, "R1 R2 R8 n=7");
        // R1: slowest ratio 64
        burst(mk(0, 63, 31, 63), 130, "R1 R2 n=63");
        // R2: asymmetric duty, low 4 high 2
        burst(mk(0, 5, 1, 5), 18, "R2 asym");
        // R4: zero period field
        burst(mk(0, 0, 0, 0), 8, "R4 div0");
        // R5: low not above high
        burst(mk(0, 4, 3, 2), 15, "R5 lo<=hi");
        // R5: clamp of the low phase to D
        burst(mk(0, 3, 1, 10), 12, "R5 clamp");
        // R6: bypass ignores fields
        burst(mk(1, 9, 4, 9), 10, "R6 bypass");
        // R3: upper bits ignored
        burst(mk(0, 2, 1, 2) | 32'h7FFC_0000, 12, "R3 junk bits");
        // R9: abort during high phase, R7 restart with full low phase
        burst(mk(0, 7, 3, 7), 6, "R9 abort");
        burst(mk(0, 7, 3, 7), 10, "R7 restart");
        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule